// File: doc/BRIEF.md
# Conversion Start and Busy Sequencer

This block is the timing controller of a sampling converter. It watches an active-low conversion-start input, moves a modelled sample-and-hold into hold, times the conversion with a cycle counter and raises a busy flag for the whole conversion. When the conversion ends it captures a supplied result word into the output register and pulses a one-cycle strobe. The falling edge of busy is the data-ready event. The analog front end is not modelled; the result word stands in for the bit decisions.

After each conversion, and after reset, the block spends a fixed number of cycles acquiring before it accepts a new start. In the normal mode a start is a falling edge of the start input, and an edge that comes during a conversion or during acquisition is dropped. In impulse mode the input is level sensitive: if it is still low when acquisition ends, the next conversion begins on that edge. A high power-down input lets a running conversion finish but blocks new ones. A high reset aborts the conversion at once.

Top module: `cnv_sequencer`

## Requirements
- R1: A falling edge on `start_n_i` that is accepted raises `hold_o` and `busy_o` together on the third rising clock edge after the input changes (two synchronizer stages plus the state register), and the two stay equal at all times.
- R2: `busy_o` stays high for exactly CONV_CYCLES clock cycles for each conversion that is not aborted.
- R3: On the edge where `busy_o` falls, `data_o` takes the value of `result_i` at that edge and `data_latched_o` is high for that one cycle only; at all other times `data_o` holds its value.
- R4: While `rst` is high, any conversion is aborted: `busy_o`, `hold_o` and `data_latched_o` are low and `data_o` is zero, and no result is captured.
- R5: While `pwr_down_i` is high no new conversion starts; a conversion already running completes and captures its result. When `pwr_down_i` returns low, starts are accepted again.
- R6: After `busy_o` falls, `busy_o` stays low for at least ACQ_CYCLES cycles. With `impulse_i` low, a falling edge of `start_n_i` that arrives while busy or before acquisition ends never starts a conversion, even if the input then stays low.
- R7: With `impulse_i` high, if `start_n_i` is low when acquisition ends a conversion starts on that edge, so a held-low input gives exactly ACQ_CYCLES low cycles of `busy_o` between conversions.
- R8: After reset is released the block is acquiring, with `busy_o`, `hold_o` and `data_latched_o` low and `data_o` zero; the first ACQ_CYCLES cycles after release count as acquisition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Asynchronous active-high reset and conversion abort |
| start_n_i | input | 1 | Active-low conversion start, asynchronous to clk |
| impulse_i | input | 1 | High selects level-sensitive impulse mode |
| pwr_down_i | input | 1 | High blocks new conversions |
| result_i | input | DATA_W | Result word captured at the end of a conversion |
| hold_o | output | 1 | Sample-and-hold control, high while holding |
| busy_o | output | 1 | High while a conversion runs |
| data_o | output | DATA_W | Output register holding the last result |
| data_latched_o | output | 1 | One-cycle strobe when a result is captured |

## Verification
The bench builds the block with DATA_W 16, CONV_CYCLES 12, ACQ_CYCLES 5 and two synchronizer stages. These short windows let edges fall inside a conversion, inside acquisition and exactly on the acquisition boundary many times over a few thousand cycles of random stimulus. The narrow windows also make impulse-mode back-to-back conversions and power-down arriving mid-conversion frequent enough to be hit both by directed cases and by the random run.

// File: rtl/cnv_seq_pkg.sv
package cnv_seq_pkg;

   typedef enum logic [0:0] {
      ST_ACQ  = 1'b0,
      ST_CONV = 1'b1
   } seq_state_t;

   function automatic int cnt_width(input int limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction

endpackage

// File: rtl/cnv_start_sync.sv
module cnv_start_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_n_i,
   output logic level_n_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain_q[0] <= 1'b1;
            else     chain_q[0] <= async_n_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain_q[i] <= 1'b1;
            else     chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) prev_q <= 1'b1;
      else     prev_q <= chain_q[STAGES-1];
   end

   assign level_n_o = chain_q[STAGES-1];
   assign fall_o    = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/cnv_cycle_timer.sv
module cnv_cycle_timer #(
   parameter int LIMIT      = 8,
   parameter bit START_FULL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic load_i,
   input  logic run_i,
   output logic zero_o
);
   import cnv_seq_pkg::*;

   localparam int              CW   = cnt_width(LIMIT);
   localparam logic [CW-1:0]   TOP  = CW'(LIMIT - 1);
   localparam logic [CW-1:0]   INIT = START_FULL ? TOP : '0;

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)                          cnt_q <= INIT;
      else if (load_i)                  cnt_q <= TOP;
      else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cnv_sequencer.sv
module cnv_sequencer #(
   parameter int DATA_W      = 16,
   parameter int CONV_CYCLES = 20,
   parameter int ACQ_CYCLES  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_n_i,
   input  logic              impulse_i,
   input  logic              pwr_down_i,
   input  logic [DATA_W-1:0] result_i,
   output logic              hold_o,
   output logic              busy_o,
   output logic [DATA_W-1:0] data_o,
   output logic              data_latched_o
);
   import cnv_seq_pkg::*;

   if (DATA_W < 1) begin : g_bad_width
      $error("cnv_sequencer: DATA_W must be at least 1");
   end
   if (CONV_CYCLES < 1) begin : g_bad_conv
      $error("cnv_sequencer: CONV_CYCLES must be at least 1");
   end
   if (ACQ_CYCLES < 1) begin : g_bad_acq
      $error("cnv_sequencer: ACQ_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cnv_sequencer: SYNC_STAGES must be at least 2");
   end

   seq_state_t        state_q;
   logic              start_level_n;
   logic              start_fall;
   logic              conv_zero;
   logic              acq_zero;
   logic              want_start;
   logic              fire;
   logic              finish;
   logic              hold_q;
   logic              busy_q;
   logic              stb_q;
   logic [DATA_W-1:0] data_q;

   cnv_start_sync #(
      .STAGES    (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst       (rst),
      .async_n_i (start_n_i),
      .level_n_o (start_level_n),
      .fall_o    (start_fall)
   );

   // conversion timer: loaded on the accepted start, counts while converting
   cnv_cycle_timer #(
      .LIMIT      (CONV_CYCLES),
      .START_FULL (1'b0)
   ) u_conv_tmr (
      .clk    (clk),
      .rst    (rst),
      .load_i (fire),
      .run_i  (state_q == ST_CONV),
      .zero_o (conv_zero)
   );

   // acquisition timer: full after reset and after each conversion
   cnv_cycle_timer #(
      .LIMIT      (ACQ_CYCLES),
      .START_FULL (1'b1)
   ) u_acq_tmr (
      .clk    (clk),
      .rst    (rst),
      .load_i (finish),
      .run_i  (state_q == ST_ACQ),
      .zero_o (acq_zero)
   );

   always_comb begin
      want_start = impulse_i ? ~start_level_n : start_fall;
      fire       = (state_q == ST_ACQ) && acq_zero && !pwr_down_i && want_start;
      finish     = (state_q == ST_CONV) && conv_zero;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state_q <= ST_ACQ;
         busy_q  <= 1'b0;
         hold_q  <= 1'b0;
      end else if (fire) begin
         state_q <= ST_CONV;
         busy_q  <= 1'b1;
         hold_q  <= 1'b1;
      end else if (finish) begin
         state_q <= ST_ACQ;
         busy_q  <= 1'b0;
         hold_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         data_q <= '0;
         stb_q  <= 1'b0;
      end else begin
         stb_q <= finish;
         if (finish) data_q <= result_i;
      end
   end

   assign hold_o         = hold_q;
   assign busy_o         = busy_q;
   assign data_o         = data_q;
   assign data_latched_o = stb_q;

endmodule

// File: rtl/cnv_seq_checker.sv
module cnv_seq_checker #(
   parameter int DATA_W      = 16,
   parameter int CONV_CYCLES = 20,
   parameter int ACQ_CYCLES  = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              pwr_down_i,
   input logic              hold_o,
   input logic              busy_o,
   input logic [DATA_W-1:0] data_o,
   input logic              data_latched_o
);

   logic [31:0] high_run_q;
   logic [31:0] low_run_q;
   logic        seen_end_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         high_run_q <= '0;
         low_run_q  <= '0;
         seen_end_q <= 1'b0;
      end else begin
         if (busy_o) begin
            if (high_run_q != '1) high_run_q <= high_run_q + 1'b1;
            low_run_q <= '0;
         end else begin
            if (low_run_q != '1) low_run_q <= low_run_q + 1'b1;
            high_run_q <= '0;
         end
         if (data_latched_o) seen_end_q <= 1'b1;
      end
   end

   AST_HOLD_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
      hold_o == busy_o); // R1

   AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_o) |-> high_run_q == CONV_CYCLES); // R2

   AST_STROBE_AT_END: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_o) |-> data_latched_o); // R3

   AST_STROBE_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
      data_latched_o |-> (!busy_o && $past(busy_o))); // R3

   AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
      !data_latched_o |-> $stable(data_o)); // R3

   AST_PD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (pwr_down_i && !busy_o) |=> !busy_o); // R5

   AST_ACQ_GAP: assert property (@(posedge clk) disable iff (rst)
      ($rose(busy_o) && seen_end_q) |-> low_run_q >= ACQ_CYCLES); // R6

endmodule

bind cnv_sequencer cnv_seq_checker #(
   .DATA_W      (DATA_W),
   .CONV_CYCLES (CONV_CYCLES),
   .ACQ_CYCLES  (ACQ_CYCLES)
) u_chk (
   .clk            (clk),
   .rst            (rst),
   .pwr_down_i     (pwr_down_i),
   .hold_o         (hold_o),
   .busy_o         (busy_o),
   .data_o         (data_o),
   .data_latched_o (data_latched_o)
);

// File: tb/cnv_sequencer_test.sv
module cnv_sequencer_test;

   localparam int DW   = 16;
   localparam int CONV = 12;
   localparam int ACQ  = 5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start_n = 1'b1;
   logic          imp = 1'b0;
   logic          pd = 1'b0;
   logic [DW-1:0] result = '0;
   logic          hold, busy, stb;
   logic [DW-1:0] data;

   int vectors = 0;
   int fails   = 0;

   always #5 clk = ~clk;

   cnv_sequencer #(
      .DATA_W(DW), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ), .SYNC_STAGES(2)
   ) uut (
      .clk(clk), .rst(rst), .start_n_i(start_n), .impulse_i(imp),
      .pwr_down_i(pd), .result_i(result), .hold_o(hold), .busy_o(busy),
      .data_o(data), .data_latched_o(stb)
   );

   // reference model built from the requirements
   logic          m_s1, m_s2, m_s3, m_busy, m_stb;
   int            m_left, m_acq;
   logic [DW-1:0] m_data;

   function automatic logic start_wanted(input logic impulse, input logic lvl_n,
                                         input logic prev_n);
      return impulse ? !lvl_n : (prev_n && !lvl_n);
   endfunction

   always @(posedge clk or posedge rst) begin
      if (rst) begin
         m_s1 <= 1'b1; m_s2 <= 1'b1; m_s3 <= 1'b1;
         m_busy <= 1'b0; m_stb <= 1'b0; m_left <= 0;
         m_acq <= ACQ - 1; m_data <= '0;
      end else begin
         m_s1 <= start_n; m_s2 <= m_s1; m_s3 <= m_s2;
         m_stb <= 1'b0;
         if (m_busy) begin
            if (m_left == 1) begin
               m_busy <= 1'b0; m_data <= result; m_stb <= 1'b1; m_acq <= ACQ - 1;
            end else begin
               m_left <= m_left - 1;
            end
         end else if (m_acq != 0) begin
            m_acq <= m_acq - 1;
         end else if (!pd && start_wanted(imp, m_s2, m_s3)) begin
            m_busy <= 1'b1; m_left <= CONV;
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      chk("R1", "hold vs model", 32'(hold), 32'(m_busy));
      chk("R2", "busy vs model", 32'(busy), 32'(m_busy));
      chk("R3", "strobe vs model", 32'(stb), 32'(m_stb));
      chk("R3", "data vs model", 32'(data), 32'(m_data));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int n;
      void'($urandom(32'h5EC1_0A27));
      repeat (3) step();
      rst = 1'b0;
      step();
      // R8: state after reset release
      chk("R8", "busy after reset", 32'(busy), 0);
      chk("R8", "hold after reset", 32'(hold), 0);
      chk("R8", "strobe after reset", 32'(stb), 0);
      chk("R8", "data after reset", 32'(data), 0);
      repeat (ACQ + 2) step();

      // R1: third edge after the falling edge
      result = 16'hA5C3;
      start_n = 1'b0;
      step(); chk("R1", "busy after 1 edge", 32'(busy), 0);
      step(); chk("R1", "busy after 2 edges", 32'(busy), 0);
      step(); chk("R1", "busy after 3 edges", 32'(busy), 1);
      chk("R1", "hold after 3 edges", 32'(hold), 1);
      start_n = 1'b1;
      n = 1;
      while (busy && n < 100) begin step(); if (busy) n++; end
      chk("R2", "busy length", 32'(n), 32'(CONV));
      chk("R3", "strobe at busy fall", 32'(stb), 1);
      chk("R3", "captured result", 32'(data), 32'hA5C3);
      result = 16'h1234;
      step(); chk("R3", "strobe one cycle", 32'(stb), 0);
      chk("R3", "data held", 32'(data), 32'hA5C3);

      // R6: an edge during busy is dropped, held-low level ignored
      repeat (ACQ + 3) step();
      start_n = 1'b0;
      repeat (3) step();
      start_n = 1'b1;
      repeat (2) step();
      start_n = 1'b0;
      repeat (2) step();
      while (busy) step();
      for (int i = 0; i < 3 * ACQ + 5; i++) begin
         step(); chk("R6", "no start from dropped edge", 32'(busy), 0);
      end

      // R7: impulse mode, held low
      imp = 1'b1;
      n = 0;
      while (!busy && n < 100) begin step(); n++; end
      while (busy) step();
      n = 1;
      while (!busy && n < 100) begin step(); if (!busy) n++; end
      chk("R7", "gap between impulse conversions", 32'(n), 32'(ACQ));

      // R5: power-down mid conversion
      step();
      pd = 1'b1;
      while (busy) step();
      chk("R5", "conversion completes under power-down", 32'(stb), 1);
      for (int i = 0; i < 3 * ACQ + CONV; i++) begin
         step(); chk("R5", "no start while powered down", 32'(busy), 0);
      end
      pd = 1'b0;
      step(); chk("R5", "start resumes after power-down", 32'(busy), 1);

      // R4: abort by reset
      repeat (4) step();
      rst = 1'b1;
      step();
      chk("R4", "busy on abort", 32'(busy), 0);
      chk("R4", "hold on abort", 32'(hold), 0);
      chk("R4", "strobe on abort", 32'(stb), 0);
      chk("R4", "data on abort", 32'(data), 0);
      rst = 1'b0; imp = 1'b0; start_n = 1'b1;
      repeat (ACQ + 4) step();

      // random phase, all requirements via the model
      for (int i = 0; i < 4000; i++) begin
         step();
         result = DW'($urandom);
         if ($urandom % 6 == 0)   start_n = ~start_n;
         if ($urandom % 40 == 0)  pd = ~pd;
         if ($urandom % 120 == 0) imp = ~imp;
         rst = ($urandom % 500 == 0);
      end
      rst = 1'b0;
      step();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule